// File: doc/BRIEF.md
# Fast Position Estimator with Deviation Monitor

This block keeps the most recent fast position and speed received over an encoder feedback link and presents them to the drive control loop. Each incoming frame arrives as a one-cycle strobe. It is marked either good or bad. A bad frame is one where the encoder sent a "position not valid" marker, or where the frame failed its CRC or line-code check. A good frame is latched as received. A bad frame is replaced by a constant-velocity prediction: the position advances by the last good speed, and the speed output keeps that last good speed.

While predicted values are on the outputs, an estimator flag stays high, with no timeout. An uncertainty bound grows from a packed acceleration limit and is reported in position LSBs. When that bound passes a programmable maximum deviation, a threshold error is raised. The acceleration limit is given as a small floating-point byte: a two-bit scale selector and a six-bit mantissa. The block also outputs the decoded limit, so the application can confirm its setting.

Top module: `pos_estimator`

## Requirements
- R1: `pos_out` holds only the MEAS_BITS low bits of the 40-bit position (default 30). Every bit above them is always 0.
- R2: The cycle after a strobe with `sample_valid`=1 and `sample_bad`=0, `pos_out` equals `pos_in` masked to MEAS_BITS, and `vel_out` equals `vel_in`.
- R3: The cycle after a `sample_bad` strobe, `pos_out` equals the previous `pos_out` plus the sign-extended `vel_out`, modulo 2^MEAS_BITS. `vel_out` is unchanged.
- R4: `estimator_on` is 1 from the cycle after any bad strobe until a good strobe clears it. It has no timeout.
- R5: `acc_limit_out` = mantissa × 4^scale, in units of 1/256 of the acceleration LSB. The mantissa is `maxacc_in[5:0]` and the scale is `maxacc_in[7:6]`. Scale 00 means /256, 01 means /64, 10 means /16 and 11 means /4. So 0x1B gives 27 and 0x54 gives 80.
- R6: On the n-th consecutive bad frame, an internal accumulator in 1/256 units grows by `acc_limit_out` × n. While the estimator is on, `uncert_out` = floor(accumulator / 256) + 1, which is never 0. Otherwise `uncert_out` is 0.
- R7: `dev_thr_err` = `estimator_on` AND (`uncert_out` > `maxdev_in`). It follows `maxdev_in` in the same cycle.
- R8: A good strobe clears `estimator_on`, `uncert_out`, the accumulator, the frame count and `dev_thr_err` in the same cycle that it loads the position.
- R9: When `sample_valid` and `sample_bad` are both 1 in the same cycle, the frame is treated as bad.
- R10: In a cycle with no strobe, `pos_out`, `vel_out`, `estimator_on` and `uncert_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Frame strobe: a sample has arrived |
| sample_bad | input | 1 | Frame strobe: the sample is unusable (marker or check failure) |
| pos_in | input | 40 | Received position |
| vel_in | input | 24 | Received signed speed |
| maxdev_in | input | 40 | Maximum accepted deviation, in position LSBs |
| maxacc_in | input | 8 | Packed acceleration limit |
| pos_out | output | 40 | Current position, received or predicted |
| vel_out | output | 24 | Current signed speed |
| estimator_on | output | 1 | Predicted values are being supplied |
| uncert_out | output | 40 | Uncertainty bound, in position LSBs |
| dev_thr_err | output | 1 | Uncertainty bound exceeds the maximum deviation |
| acc_limit_out | output | 12 | Decoded acceleration limit, in 1/256 units |

## Verification
The good-frame strobe and the bad-frame strobe can arrive in the same cycle. The bench provokes this in the middle of an estimation run and again from the idle state. It judges the result as a bad frame: the position advances by the held speed, the received value is not taken, and the uncertainty takes its next step. A second collision is also covered: a good frame that arrives while `dev_thr_err` is high. The bench expects the new position, a cleared flag and zero uncertainty in one and the same cycle.

// File: rtl/pos_est_pkg.sv
package pos_est_pkg;

  localparam int unsigned ACC_REG_W  = 8;
  localparam int unsigned ACC_MANT_W = 6;
  localparam int unsigned ACC_FX_W   = ACC_MANT_W + 6;
  localparam int unsigned FRAC_W     = 8;

  // mantissa scaled to 1/256 units: shift by twice the scale code
  function automatic logic [ACC_FX_W-1:0] decode_acc(input logic [ACC_REG_W-1:0] reg_val);
    logic [ACC_FX_W-1:0] mant;
    mant = {{(ACC_FX_W-ACC_MANT_W){1'b0}}, reg_val[ACC_MANT_W-1:0]};
    case (reg_val[7:6])
      2'b00:   decode_acc = mant;
      2'b01:   decode_acc = mant << 2;
      2'b10:   decode_acc = mant << 4;
      default: decode_acc = mant << 6;
    endcase
  endfunction

endpackage

// File: rtl/pe_acc_decode.sv
module pe_acc_decode
  import pos_est_pkg::*;
(
  input  logic [ACC_REG_W-1:0] maxacc,
  output logic [ACC_FX_W-1:0]  acc_fx
);
  always_comb acc_fx = decode_acc(maxacc);
endmodule

// File: rtl/pe_track.sv
module pe_track #(
  parameter int unsigned POS_W     = 40,
  parameter int unsigned VEL_W     = 24,
  parameter int unsigned MEAS_BITS = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_ev,
  input  logic                    est_ev,
  input  logic [POS_W-1:0]        pos_in,
  input  logic signed [VEL_W-1:0] vel_in,
  output logic [POS_W-1:0]        pos_q,
  output logic signed [VEL_W-1:0] vel_q
);
  localparam logic [POS_W-1:0] POS_MASK = {POS_W{1'b1}} >> (POS_W - MEAS_BITS);

  function automatic logic [POS_W-1:0] extend_vel(input logic signed [VEL_W-1:0] v);
    return {{(POS_W-VEL_W){v[VEL_W-1]}}, v};
  endfunction

  logic [POS_W-1:0] pos_pred;
  always_comb pos_pred = (pos_q + extend_vel(vel_q)) & POS_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      vel_q <= '0;
    end else if (est_ev) begin
      pos_q <= pos_pred;
    end else if (load_ev) begin
      pos_q <= pos_in & POS_MASK;
      vel_q <= vel_in;
    end
  end
endmodule

// File: rtl/pe_uncert.sv
module pe_uncert
  import pos_est_pkg::*;
#(
  parameter int unsigned DEV_W = 40,
  parameter int unsigned CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_ev,
  input  logic                est_ev,
  input  logic [ACC_FX_W-1:0] acc_fx,
  input  logic [DEV_W-1:0]    maxdev,
  output logic                est_on,
  output logic [DEV_W-1:0]    uncert,
  output logic                dev_err
);
  localparam int unsigned UNC_W  = DEV_W + FRAC_W;
  localparam int unsigned PROD_W = ACC_FX_W + CNT_W;

  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [UNC_W-1:0]  acc_q, acc_nx;
  logic [PROD_W-1:0] step;
  logic [UNC_W:0]    sum;
  logic [DEV_W-1:0]  whole;

  always_comb begin
    cnt_nx = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    step   = {{CNT_W{1'b0}}, acc_fx} * {{ACC_FX_W{1'b0}}, cnt_nx};
    sum    = {1'b0, acc_q} + {{(UNC_W+1-PROD_W){1'b0}}, step};
    acc_nx = sum[UNC_W] ? {UNC_W{1'b1}} : sum[UNC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      est_on <= 1'b0;
    end else if (est_ev) begin
      cnt_q  <= cnt_nx;
      acc_q  <= acc_nx;
      est_on <= 1'b1;
    end else if (load_ev) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      est_on <= 1'b0;
    end
  end

  always_comb begin
    whole   = acc_q[UNC_W-1:FRAC_W];
    uncert  = !est_on ? '0 : ((&whole) ? whole : whole + 1'b1);
    dev_err = est_on && (uncert > maxdev);
  end
endmodule

// File: rtl/pos_estimator.sv
module pos_estimator
  import pos_est_pkg::*;
#(
  parameter int unsigned MEAS_BITS = 30,
  parameter int unsigned CNT_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_valid,
  input  logic               sample_bad,
  input  logic [39:0]        pos_in,
  input  logic signed [23:0] vel_in,
  input  logic [39:0]        maxdev_in,
  input  logic [7:0]         maxacc_in,
  output logic [39:0]        pos_out,
  output logic signed [23:0] vel_out,
  output logic               estimator_on,
  output logic [39:0]        uncert_out,
  output logic               dev_thr_err,
  output logic [11:0]        acc_limit_out
);
  localparam int unsigned POS_W = 40;
  localparam int unsigned VEL_W = 24;

  // named events for the checker
  logic load_ev;
  logic est_ev;
  always_comb begin
    est_ev  = sample_bad;
    load_ev = sample_valid && !sample_bad;
  end

  logic [ACC_FX_W-1:0] acc_fx;

  pe_acc_decode u_dec (
    .maxacc (maxacc_in),
    .acc_fx (acc_fx)
  );

  pe_track #(.POS_W(POS_W), .VEL_W(VEL_W), .MEAS_BITS(MEAS_BITS)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .est_ev  (est_ev),
    .pos_in  (pos_in),
    .vel_in  (vel_in),
    .pos_q   (pos_out),
    .vel_q   (vel_out)
  );

  pe_uncert #(.DEV_W(POS_W), .CNT_W(CNT_W)) u_unc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .est_ev  (est_ev),
    .acc_fx  (acc_fx),
    .maxdev  (maxdev_in),
    .est_on  (estimator_on),
    .uncert  (uncert_out),
    .dev_err (dev_thr_err)
  );

  assign acc_limit_out = acc_fx;
endmodule

// File: rtl/pos_estimator_chk.sv
module pos_estimator_chk #(
  parameter int unsigned MEAS_BITS = 30
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sample_valid,
  input logic               sample_bad,
  input logic               load_ev,
  input logic               est_ev,
  input logic [39:0]        pos_in,
  input logic signed [23:0] vel_in,
  input logic [39:0]        pos_out,
  input logic signed [23:0] vel_out,
  input logic               estimator_on,
  input logic [39:0]        uncert_out,
  input logic               dev_thr_err
);
  localparam logic [39:0] MASK = {40{1'b1}} >> (40 - MEAS_BITS);

  function automatic logic [39:0] advance(input logic [39:0] p, input logic signed [23:0] v);
    return (p + {{16{v[23]}}, v}) & MASK;
  endfunction

  // R1
  pos_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_out & ~MASK) == 40'd0);

  // R2
  load_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (pos_out == ($past(pos_in) & MASK)) && (vel_out == $past(vel_in)));

  // R3
  extrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_ev |=> (pos_out == advance($past(pos_out), $past(vel_out))) && $stable(vel_out));

  // R4
  est_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_ev |=> estimator_on);

  // R6
  active_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    estimator_on |-> (uncert_out != 40'd0));

  // R7
  err_needs_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_thr_err |-> estimator_on);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> !estimator_on && !dev_thr_err && (uncert_out == 40'd0));

  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && sample_bad) |=> estimator_on);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !sample_bad) |=> $stable(pos_out) && $stable(vel_out)
      && $stable(estimator_on) && $stable(uncert_out));
endmodule

bind pos_estimator pos_estimator_chk #(.MEAS_BITS(MEAS_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .sample_bad   (sample_bad),
  .load_ev      (load_ev),
  .est_ev       (est_ev),
  .pos_in       (pos_in),
  .vel_in       (vel_in),
  .pos_out      (pos_out),
  .vel_out      (vel_out),
  .estimator_on (estimator_on),
  .uncert_out   (uncert_out),
  .dev_thr_err  (dev_thr_err)
);

// File: tb/pos_estimator_tb.sv
module pos_estimator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEAS = 30;
  localparam longint MOD = longint'(1) << MEAS;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sample_valid = 1'b0;
  logic               sample_bad = 1'b0;
  logic [39:0]        pos_in = '0;
  logic signed [23:0] vel_in = '0;
  logic [39:0]        maxdev_in = '0;
  logic [7:0]         maxacc_in = '0;
  logic [39:0]        pos_out;
  logic signed [23:0] vel_out;
  logic               estimator_on;
  logic [39:0]        uncert_out;
  logic               dev_thr_err;
  logic [11:0]        acc_limit_out;

  pos_estimator u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  // bench model
  longint m_pos = 0, m_vel = 0, m_fx = 0, m_n = 0;
  bit     m_on = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint acc_of(input logic [7:0] r);
    return longint'(r[5:0]) * (longint'(1) << (2 * r[7:6]));
  endfunction

  task automatic check_all(input string tag);
    longint eu;
    eu = m_on ? (m_fx >> 8) + 1 : 0;
    chk({tag, " pos"}, longint'(pos_out), m_pos);
    chk({tag, " vel"}, longint'(vel_out), m_vel);
    chk({tag, " est_on"}, longint'(estimator_on), longint'(m_on));
    chk({tag, " uncert"}, longint'(uncert_out), eu);
    chk({tag, " dev_err"}, longint'(dev_thr_err), longint'(m_on && eu > longint'(maxdev_in)));
  endtask

  task automatic step(input bit v, input bit b, input longint p, input longint vel);
    @(negedge clk);
    sample_valid = v; sample_bad = b;
    pos_in = p[39:0]; vel_in = vel[23:0];
    @(posedge clk);
    if (b) begin
      m_n++;
      m_fx += acc_of(maxacc_in) * m_n;
      m_pos = (m_pos + m_vel) % MOD;
      if (m_pos < 0) m_pos += MOD;
      m_on = 1;
    end else if (v) begin
      m_pos = p & (MOD - 1);
      m_vel = vel;
      m_on = 0; m_fx = 0; m_n = 0;
    end
    #(CLK_PERIOD/4);
    sample_valid = 0; sample_bad = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_all("reset");
    rst_n = 1'b1;

    // R5: sweep the whole acceleration register
    for (int r = 0; r < 256; r++) begin
      maxacc_in = r[7:0];
      #1;
      chk("R5 decode", longint'(acc_limit_out), acc_of(r[7:0]));
    end
    maxacc_in = 8'h1B; #1;
    chk("R5 0x1B", longint'(acc_limit_out), 27);
    maxacc_in = 8'h54; #1;
    chk("R5 0x54", longint'(acc_limit_out), 80);

    // R1 R2: load with upper bits set
    step(1, 0, 64'h00FF_C000_1234, 1000);
    check_all("R1 R2 load");
    chk("R1 upper", longint'(pos_out >> MEAS), 0);

    // R10: idle cycles hold
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_all("R10 idle");

    // R3 R4 R6 R7: run of bad frames with 0x1B and small limit
    maxacc_in = 8'h1B; maxdev_in = 40'd3;
    for (int k = 0; k < 10; k++) begin
      step(0, 1, 0, 0);
      check_all("R3 R4 R6 R7 est");
    end
    // R10: hold while estimating
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    check_all("R10 est hold");
    // R7: threshold follows maxdev combinationally
    maxdev_in = 40'd100; #1;
    check_all("R7 maxdev raised");
    maxdev_in = 40'd3; #1;

    // R9: collision mid-run
    step(1, 1, 64'h5555, 7);
    check_all("R9 collide");

    // R8: good frame while dev error active
    chk("R8 pre err", longint'(dev_thr_err), 1);
    step(1, 0, 64'h10, -24'sd40);
    check_all("R8 clear");

    // R3: negative speed wraps below zero
    maxacc_in = 8'hFF; maxdev_in = 40'd1000;
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 0, 0);
      check_all("R3 wrap");
    end
    chk("R3 wrapped", longint'(pos_out), MOD - 144);

    // R2: loads across several patterns
    for (int k = 0; k < 8; k++) begin
      step(1, 0, (longint'(k) * 64'h1357_9BDF) ^ 64'hAB_0000_0000, (k * 2791) - 9000);
      check_all("R2 pattern");
    end

    // R9: collision from idle, then recovery
    maxacc_in = 8'h54; maxdev_in = 40'd0;
    step(1, 1, 64'h77, 3);
    check_all("R9 idle collide");
    for (int k = 0; k < 5; k++) begin
      step(0, 1, 0, 0);
      check_all("R6 0x54 run");
    end
    step(1, 0, 64'h3FFF_FFFF, 1);
    check_all("R8 final");
    step(0, 1, 0, 0);
    check_all("R3 wrap top");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule